// File: doc/BRIEF.md
# Dual-Lane Accumulator Saturation Unit

This block sits after the adders of a two-lane multiply-accumulate datapath. For each lane it receives the raw, pre-saturation sum (wider than the 40-bit accumulator) together with a mode code and some qualifiers. It then clamps or wraps the sum into the 40-bit accumulator according to that mode, and keeps the accumulator and its status flags in registers. Each lane has its own flags: a per-operation saturation flag and a sticky copy of it. A combined overflow bit and a combined sticky overflow bit summarise both lanes.

A transaction is presented with `in_valid` high for one cycle. All inputs are sampled at that clock edge. The updated accumulators and flags, plus an `out_valid` strobe, are visible from that edge until the next accepted transaction. A small sequencer with two states, CT_IDLE and CT_RESULT, produces `out_valid`:
- T_ACCEPT moves CT_IDLE to CT_RESULT when `in_valid` is high.
- T_STREAM keeps CT_RESULT on back-to-back transactions.
- T_DRAIN returns CT_RESULT to CT_IDLE when no transaction arrives.

Lane modes (3-bit code):
- 0: signed fraction, 40-bit signed clamp.
- 1: unsigned fraction.
- 2: unsigned integer.
- 3: truncated unsigned fraction.
- 4: signed 32-bit integer clamp.
- 5: 32-bit wrap.
- 6 and 7: undefined.

The lane operation code value 3 means "no accumulation" for that lane.

Top module: `dualmac_sat`

## Requirements
- R1: Synchronous reset (active-high `rst`) clears both accumulators, every lane flag, `v`, `vs`, `illegal` and `out_valid`.
- R2: A transaction accepted with `in_valid` high at a clock edge shows its results, and `out_valid` high, right after that edge. `out_valid` is low after any edge where `in_valid` was low.
- R3: Mode 0 clamps the signed sum to the range 0x8000000000..0x7FFFFFFFFF, read as 40-bit two's complement. Any clamp sets the lane saturation flag; a sum inside the range passes through unchanged.
- R4: In modes 1, 2 and 3 with the mixed flag low, a negative sum gives 0 and a sum above 0xFFFFFFFFFF gives 0xFFFFFFFFFF. Both cases set saturation.
- R5: In modes 1, 2 and 3 with the mixed flag high, the result is the low 40 bits of the sum and saturation stays clear.
- R6: Mode 4 clamps the sum to -0x80000000..0x7FFFFFFF, sign-extended into 40 bits, and sets saturation when it clamps.
- R7: In mode 5, bits 39..31 of the sum are checked. If they are neither all zeros nor all ones, the result is 0xFF80000000 when bit 39 is 1 and 0x7FFFFFFF otherwise, with saturation set. If they are uniform, the result is bits 31..0 sign-extended from bit 31.
- R8: In mode 5, a high multiplier-saturated input also sets the lane saturation flag.
- R9: A lane whose operation code is 3 keeps its accumulator and its saturation flag, and contributes 0 to `v`.
- R10: Each accumulating lane writes its saturation flag (`av0`/`av1`) with this operation's saturation. Its sticky flag (`avs0`/`avs1`) is set when saturation is 1 and is only cleared by reset.
- R11: A lane's overflow is 1 when it saturated with a full-word output. Otherwise it equals that lane's extraction-overflow input. `v` is written on every transaction with the OR of both lanes' overflow.
- R12: `vs` is set whenever `v` is written as 1 and is only cleared by reset.
- R13: An active lane with mode 6 or 7 leaves its accumulator and flags unchanged and contributes no overflow. `illegal` is then high for exactly the result cycle of that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transaction strobe |
| sum0 | input | 48 | Lane 0 pre-saturation sum, signed |
| mode0 | input | 3 | Lane 0 mode code |
| mixed0 | input | 1 | Lane 0 mixed-mode flag |
| msat0 | input | 1 | Lane 0 multiplier saturated |
| op0 | input | 2 | Lane 0 operation code, 3 = no accumulation |
| full0 | input | 1 | Lane 0 output is full-word |
| xovf0 | input | 1 | Lane 0 extraction overflow of the unsaturated sum |
| sum1 | input | 48 | Lane 1 pre-saturation sum, signed |
| mode1 | input | 3 | Lane 1 mode code |
| mixed1 | input | 1 | Lane 1 mixed-mode flag |
| msat1 | input | 1 | Lane 1 multiplier saturated |
| op1 | input | 2 | Lane 1 operation code, 3 = no accumulation |
| full1 | input | 1 | Lane 1 output is full-word |
| xovf1 | input | 1 | Lane 1 extraction overflow of the unsaturated sum |
| out_valid | output | 1 | Results of the last transaction are presented |
| acc0 | output | 40 | Lane 0 accumulator |
| acc1 | output | 40 | Lane 1 accumulator |
| av0 | output | 1 | Lane 0 saturation flag |
| av1 | output | 1 | Lane 1 saturation flag |
| avs0 | output | 1 | Lane 0 sticky saturation |
| avs1 | output | 1 | Lane 1 sticky saturation |
| v | output | 1 | Combined overflow |
| vs | output | 1 | Combined sticky overflow |
| illegal | output | 1 | Undefined mode seen on an active lane |

## Verification
The bench drives sums sitting exactly on and one past each clamp limit. A design with an off-by-one bound would saturate a legal extreme or pass an out-of-range value. It places mode-5 sums where only bit 31 disagrees with bits 39..32, which catches a design that checks only bits 39..32 and therefore wraps instead of forcing 0x7FFFFFFF. Mixed-mode unsigned sums, inactive lanes and undefined modes are interleaved with saturating traffic. This exposes a design that clamps when it should wrap, updates a lane that had no work, or lets an illegal lane raise `v`. Half-word saturations with a clear extraction-overflow input check that `v` follows the extraction input rather than the saturation flag, and that the sticky bits survive later clean operations.

// File: rtl/macsat_pkg.sv
package macsat_pkg;

    localparam int LANES = 2;

    typedef enum logic [2:0] {
        MD_SFRAC  = 3'd0,
        MD_UFRAC  = 3'd1,
        MD_UINT   = 3'd2,
        MD_TUFRAC = 3'd3,
        MD_SINT32 = 3'd4,
        MD_WRAP32 = 3'd5
    } sat_mode_e;

    localparam logic [1:0] OP_NONE = 2'd3;

    typedef enum logic {
        CT_IDLE   = 1'b0,
        CT_RESULT = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/macsat_clamp.sv
module macsat_clamp
    import macsat_pkg::*;
#(
    parameter int SUM_W    = 48,
    parameter int ACC_W    = 40,
    parameter int NARROW_W = 32
) (
    input  logic signed [SUM_W-1:0] sum,
    input  sat_mode_e               mode,
    input  logic                    mixed,
    input  logic                    msat,
    output logic [ACC_W-1:0]        res,
    output logic                    sat,
    output logic                    legal
);

    localparam logic signed [SUM_W-1:0] SMAX_WIDE =
        {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SMIN_WIDE = ~SMAX_WIDE;
    localparam logic signed [SUM_W-1:0] UMAX_WIDE =
        {{(SUM_W-ACC_W){1'b0}}, {ACC_W{1'b1}}};
    localparam logic signed [SUM_W-1:0] SMAX_NAR =
        {{(SUM_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SMIN_NAR = ~SMAX_NAR;
    localparam logic [ACC_W-1:0] POS_LIM_NAR =
        {{(ACC_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM_NAR =
        {{(ACC_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};
    localparam int HI_W = ACC_W - NARROW_W + 1;

    logic [HI_W-1:0] hi_bits;
    logic            hi_uniform;

    assign hi_bits    = sum[ACC_W-1:NARROW_W-1];
    assign hi_uniform = (&hi_bits) | ~(|hi_bits);

    always_comb begin
        res   = sum[ACC_W-1:0];
        sat   = 1'b0;
        legal = 1'b1;
        unique case (mode)
            MD_SFRAC: begin
                if (sum > SMAX_WIDE) begin
                    res = SMAX_WIDE[ACC_W-1:0];
                    sat = 1'b1;
                end else if (sum < SMIN_WIDE) begin
                    res = SMIN_WIDE[ACC_W-1:0];
                    sat = 1'b1;
                end
            end
            MD_UFRAC, MD_UINT, MD_TUFRAC: begin
                if (!mixed) begin
                    if (sum[SUM_W-1]) begin
                        res = '0;
                        sat = 1'b1;
                    end else if (sum > UMAX_WIDE) begin
                        res = UMAX_WIDE[ACC_W-1:0];
                        sat = 1'b1;
                    end
                end
            end
            MD_SINT32: begin
                if (sum > SMAX_NAR) begin
                    res = SMAX_NAR[ACC_W-1:0];
                    sat = 1'b1;
                end else if (sum < SMIN_NAR) begin
                    res = SMIN_NAR[ACC_W-1:0];
                    sat = 1'b1;
                end
            end
            MD_WRAP32: begin
                if (!hi_uniform) begin
                    res = sum[ACC_W-1] ? NEG_LIM_NAR : POS_LIM_NAR;
                    sat = 1'b1;
                end else begin
                    res = {{(ACC_W-NARROW_W){sum[NARROW_W-1]}}, sum[NARROW_W-1:0]};
                end
                if (msat) sat = 1'b1;
            end
            default: legal = 1'b0;
        endcase
    end

    // R6 / R7: narrow modes always yield a value sign-extended from the narrow width
    always_comb begin
        if (legal && (mode == MD_SINT32 || mode == MD_WRAP32)) begin
            p_narrow_range_r6: assert ((&res[ACC_W-1:NARROW_W-1]) || ~(|res[ACC_W-1:NARROW_W-1]))
                else $error("narrow-mode result not sign-extended");
        end
    end

endmodule

// File: rtl/macsat_ctrl.sv
module macsat_ctrl
    import macsat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic out_valid
);

    ctrl_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= CT_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CT_IDLE:   if (in_valid)  st_d = CT_RESULT;   // T_ACCEPT
            CT_RESULT: if (!in_valid) st_d = CT_IDLE;     // T_DRAIN, else T_STREAM
            default:   st_d = CT_IDLE;
        endcase
    end

    always_comb begin
        out_valid = (st_q == CT_RESULT);
    end

    p_result_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_quiet_after_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: rtl/dualmac_sat.sv
module dualmac_sat
    import macsat_pkg::*;
#(
    parameter int SUM_W    = 48,
    parameter int ACC_W    = 40,
    parameter int NARROW_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SUM_W-1:0] sum0,
    input  logic [2:0]       mode0,
    input  logic             mixed0,
    input  logic             msat0,
    input  logic [1:0]       op0,
    input  logic             full0,
    input  logic             xovf0,
    input  logic [SUM_W-1:0] sum1,
    input  logic [2:0]       mode1,
    input  logic             mixed1,
    input  logic             msat1,
    input  logic [1:0]       op1,
    input  logic             full1,
    input  logic             xovf1,
    output logic             out_valid,
    output logic [ACC_W-1:0] acc0,
    output logic [ACC_W-1:0] acc1,
    output logic             av0,
    output logic             av1,
    output logic             avs0,
    output logic             avs1,
    output logic             v,
    output logic             vs,
    output logic             illegal
);

    logic signed [SUM_W-1:0] sum_a   [LANES];
    logic [2:0]              mode_a  [LANES];
    logic [1:0]              op_a    [LANES];
    logic [LANES-1:0]        mixed_a, msat_a, full_a, xovf_a;

    logic [ACC_W-1:0]        res_a   [LANES];
    logic [LANES-1:0]        sat_a, legal_a, active_a, upd_a, ovf_a, bad_a;

    logic [ACC_W-1:0]        acc_q   [LANES];
    logic [LANES-1:0]        av_q, avs_q;
    logic                    v_q, vs_q, illegal_q;

    assign sum_a[0]  = sum0;   assign sum_a[1]  = sum1;
    assign mode_a[0] = mode0;  assign mode_a[1] = mode1;
    assign op_a[0]   = op0;    assign op_a[1]   = op1;
    assign mixed_a   = {mixed1, mixed0};
    assign msat_a    = {msat1,  msat0};
    assign full_a    = {full1,  full0};
    assign xovf_a    = {xovf1,  xovf0};

    macsat_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .out_valid(out_valid)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        macsat_clamp #(
            .SUM_W   (SUM_W),
            .ACC_W   (ACC_W),
            .NARROW_W(NARROW_W)
        ) u_clamp (
            .sum  (sum_a[i]),
            .mode (sat_mode_e'(mode_a[i])),
            .mixed(mixed_a[i]),
            .msat (msat_a[i]),
            .res  (res_a[i]),
            .sat  (sat_a[i]),
            .legal(legal_a[i])
        );

        assign active_a[i] = (op_a[i] != OP_NONE);
        assign upd_a[i]    = active_a[i] & legal_a[i];
        assign bad_a[i]    = active_a[i] & ~legal_a[i];
        assign ovf_a[i]    = upd_a[i] & (xovf_a[i] | (sat_a[i] & full_a[i]));

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[i] <= '0;
                av_q[i]  <= 1'b0;
                avs_q[i] <= 1'b0;
            end else if (in_valid && upd_a[i]) begin
                acc_q[i] <= res_a[i];
                av_q[i]  <= sat_a[i];
                if (sat_a[i]) avs_q[i] <= 1'b1;
            end
        end

        p_sticky_lane_r10: assert property (@(posedge clk) disable iff (rst)
            avs_q[i] |=> avs_q[i]);
        p_av_sets_avs_r10: assert property (@(posedge clk) disable iff (rst)
            av_q[i] |-> avs_q[i]);
        p_idle_lane_hold_r9: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_a[i] == OP_NONE) |=> ($stable(acc_q[i]) && $stable(av_q[i])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q       <= 1'b0;
            vs_q      <= 1'b0;
            illegal_q <= 1'b0;
        end else if (in_valid) begin
            v_q       <= |ovf_a;
            if (|ovf_a) vs_q <= 1'b1;
            illegal_q <= |bad_a;
        end else begin
            illegal_q <= 1'b0;
        end
    end

    assign acc0    = acc_q[0];
    assign acc1    = acc_q[1];
    assign av0     = av_q[0];
    assign av1     = av_q[1];
    assign avs0    = avs_q[0];
    assign avs1    = avs_q[1];
    assign v       = v_q;
    assign vs      = vs_q;
    assign illegal = illegal_q;

    p_v_sets_vs_r12: assert property (@(posedge clk) disable iff (rst)
        v_q |-> vs_q);
    p_vs_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        vs_q |=> vs_q);
    p_illegal_cause_r13: assert property (@(posedge clk) disable iff (rst)
        illegal_q |-> $past(in_valid));
    p_no_overflow_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op0 == OP_NONE && op1 == OP_NONE) |=> !v_q);

endmodule

// File: tb/sim_dualmac_sat.sv
module sim_dualmac_sat;

    localparam int SW = 48;
    localparam int AW = 40;

    typedef struct {
        logic [AW-1:0] a0;
        logic [AW-1:0] a1;
        logic [6:0]    fl;   // {illegal, vs, v, avs1, avs0, av1, av0}
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [SW-1:0] sum0 = '0, sum1 = '0;
    logic [2:0] mode0 = '0, mode1 = '0;
    logic mixed0 = 0, mixed1 = 0, msat0 = 0, msat1 = 0;
    logic [1:0] op0 = 2'd3, op1 = 2'd3;
    logic full0 = 0, full1 = 0, xovf0 = 0, xovf1 = 0;
    logic out_valid, av0, av1, avs0, avs1, v, vs, illegal;
    logic [AW-1:0] acc0, acc1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    exp_t q[$];

    logic [AW-1:0] m_acc [2];
    bit m_av [2];
    bit m_avs [2];
    bit m_v, m_vs;

    always #4 clk = ~clk;

    dualmac_sat u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .sum0(sum0), .mode0(mode0), .mixed0(mixed0), .msat0(msat0), .op0(op0),
        .full0(full0), .xovf0(xovf0),
        .sum1(sum1), .mode1(mode1), .mixed1(mixed1), .msat1(msat1), .op1(op1),
        .full1(full1), .xovf1(xovf1),
        .out_valid(out_valid), .acc0(acc0), .acc1(acc1),
        .av0(av0), .av1(av1), .avs0(avs0), .avs1(avs1),
        .v(v), .vs(vs), .illegal(illegal)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // independent reference: returns {sat, result}
    function automatic logic [AW:0] ref_lane(input int md, input bit mx, input bit ms, input longint s);
        longint r;
        bit st;
        longint t;
        longint hi;
        st = 0;
        r = s;
        case (md)
            0: begin
                if (s > 64'sh7FFFFFFFFF) begin r = 64'sh7FFFFFFFFF; st = 1; end
                else if (s < -64'sh8000000000) begin r = -64'sh8000000000; st = 1; end
            end
            1, 2, 3: begin
                if (!mx) begin
                    if (s < 0) begin r = 0; st = 1; end
                    else if (s > 64'shFFFFFFFFFF) begin r = 64'shFFFFFFFFFF; st = 1; end
                end
            end
            4: begin
                if (s > 64'sh7FFFFFFF) begin r = 64'sh7FFFFFFF; st = 1; end
                else if (s < -64'sh80000000) begin r = -64'sh80000000; st = 1; end
            end
            default: begin
                t = s & 64'hFFFFFFFFFF;
                hi = (t >> 31) & 64'h1FF;
                if (hi != 0 && hi != 64'h1FF) begin
                    r = ((t >> 39) & 1) != 0 ? -64'sh80000000 : 64'sh7FFFFFFF;
                    st = 1;
                end else begin
                    r = longint'($signed(t[31:0]));
                end
                if (ms) st = 1;
            end
        endcase
        return {st, r[AW-1:0]};
    endfunction

    task automatic model_lane(input int i, input longint s, input int md, input bit mx, input bit ms,
                              input int op, input bit fw, input bit xo, output bit ovf, output bit bad);
        logic [AW:0] rr;
        ovf = 0;
        bad = 0;
        if (op == 3) return;
        if (md > 5) begin bad = 1; return; end
        rr = ref_lane(md, mx, ms, s);
        m_acc[i] = rr[AW-1:0];
        m_av[i] = rr[AW];
        if (rr[AW]) m_avs[i] = 1;
        ovf = xo | (rr[AW] & fw);
    endtask

    task automatic send(input string tag,
                        input longint s0, input int md0, input bit mx0, input bit ms0, input int o0, input bit fw0, input bit xo0,
                        input longint s1, input int md1, input bit mx1, input bit ms1, input int o1, input bit fw1, input bit xo1);
        exp_t e;
        bit f0, f1, b0, b1;
        sum0 = s0[SW-1:0]; mode0 = md0[2:0]; mixed0 = mx0; msat0 = ms0; op0 = o0[1:0]; full0 = fw0; xovf0 = xo0;
        sum1 = s1[SW-1:0]; mode1 = md1[2:0]; mixed1 = mx1; msat1 = ms1; op1 = o1[1:0]; full1 = fw1; xovf1 = xo1;
        in_valid = 1'b1;
        model_lane(0, s0, md0, mx0, ms0, o0, fw0, xo0, f0, b0);
        model_lane(1, s1, md1, mx1, ms1, o1, fw1, xo1, f1, b1);
        m_v = f0 | f1;
        if (m_v) m_vs = 1;
        e.a0 = m_acc[0];
        e.a1 = m_acc[1];
        e.fl = {b0 | b1, m_vs, m_v, m_avs[1], m_avs[0], m_av[1], m_av[0]};
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(0, "R2 unexpected result", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(acc0 === e.a0, {e.tag, " acc0"}, 64'(acc0), 64'(e.a0));
                check(acc1 === e.a1, {e.tag, " acc1"}, 64'(acc1), 64'(e.a1));
                check({illegal, vs, v, avs1, avs0, av1, av0} === e.fl, {e.tag, " flags"},
                      64'({illegal, vs, v, avs1, avs0, av1, av0}), 64'(e.fl));
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_av[i] = 0; m_avs[i] = 0; end
        m_v = 0; m_vs = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(acc0 == '0 && acc1 == '0, "R1 reset accumulators", 64'({acc0, acc1}), 64'd0);
        check({illegal, vs, v, avs1, avs0, av1, av0} == 7'd0, "R1 reset flags",
              64'({illegal, vs, v, avs1, avs0, av1, av0}), 64'd0);
        check(out_valid == 1'b0, "R1 reset out_valid", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R2 idle no result", 64'(out_valid), 64'd0);

        // R3: signed 40-bit limits
        send("R3 max edge / over max",
             64'sh7FFFFFFFFF, 0, 0, 0, 0, 1, 0,
             64'sh8000000000, 0, 0, 0, 0, 0, 0);
        send("R3 under min / small negative",
             -64'sh8000000001, 0, 0, 0, 1, 1, 0,
             -64'sd5, 0, 0, 0, 2, 0, 0);
        // R4: unsigned clamp, full word -> overflow (R11)
        send("R4 R11 unsigned clamp",
             -64'sd1, 2, 0, 0, 0, 1, 0,
             64'sh10000000000, 1, 0, 0, 0, 1, 0);
        send("R4 unsigned edge",
             64'shFFFFFFFFFF, 3, 0, 0, 0, 0, 0,
             64'sd0, 1, 0, 0, 0, 0, 0);
        // R5: mixed wrap
        send("R5 mixed wrap",
             64'sh123456789ABC, 2, 1, 0, 0, 1, 0,
             -64'sd3, 1, 1, 0, 0, 1, 0);
        // R6: signed 32 clamp, half word, no extraction overflow -> v low
        send("R6 R11 signed32 clamp half word",
             64'sh80000000, 4, 0, 0, 0, 0, 0,
             -64'sh80000001, 4, 0, 0, 0, 0, 0);
        send("R6 signed32 edges",
             64'sh7FFFFFFF, 4, 0, 0, 0, 0, 0,
             -64'sh80000000, 4, 0, 0, 0, 0, 1);
        // R7: wrap mode sign disagreement, bit31-only case
        send("R7 wrap32 force",
             64'sh0080000000, 5, 0, 0, 0, 0, 0,
             64'shFF7FFFFFFF, 5, 0, 0, 0, 0, 0);
        // R7/R8: uniform upper bits, multiplier saturation
        send("R7 R8 wrap32 pass and msat",
             64'shFFFFFFFF80, 5, 0, 1, 0, 1, 0,
             64'sh0000012345, 5, 0, 0, 0, 1, 0);
        // R9: lane 0 idle
        send("R9 idle lane",
             64'sh7FFFFFFFFFFF, 0, 0, 0, 3, 1, 1,
             64'sd77, 0, 0, 0, 0, 0, 0);
        // R13: undefined mode on active lane
        send("R13 illegal mode",
             64'sd999, 6, 0, 0, 0, 1, 1,
             64'sd11, 0, 0, 0, 0, 0, 0);
        send("R13 illegal clears",
             64'sd12, 0, 0, 0, 0, 0, 0,
             64'sd13, 7, 0, 0, 3, 0, 0);
        // R12: clean op leaves vs set, v low
        send("R12 sticky vs",
             64'sd1, 0, 0, 0, 0, 0, 0,
             64'sd2, 0, 0, 0, 0, 0, 0);
        // R10: lane sticky flags survive; av rewritten
        send("R10 av rewrite",
             64'sd3, 1, 0, 0, 0, 0, 0,
             64'sh7FFFFFFF, 5, 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);

        // mixed traffic, back to back
        for (int k = 0; k < 80; k++) begin
            logic [63:0] r0, r1;
            longint s0, s1;
            r0 = {$urandom(), $urandom()};
            r1 = {$urandom(), $urandom()};
            case (k % 3)
                0: begin s0 = longint'($signed(r0[47:0])); s1 = longint'($signed(r1[40:0])); end
                1: begin s0 = longint'($signed(r0[33:0])); s1 = longint'($signed(r1[47:0])); end
                default: begin s0 = longint'($signed(r0[40:0])); s1 = longint'($signed(r1[33:0])); end
            endcase
            send("R11 mixed traffic",
                 s0, int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                 int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                 s1, int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                 int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
            if (k % 7 == 0) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R2 all results seen", 64'(q.size()), 64'd0);
        check(out_valid == 1'b0, "R2 drained", 64'(out_valid), 64'd0);
        check(illegal == 1'b0, "R13 no pulse when idle", 64'(illegal), 64'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule